// File: doc/BRIEF.md
# Biphase Mark Line Encoder

This block turns each 32-bit data word into a 64-cell biphase-mark stream for a consumer-audio style serial output. Each data bit becomes a two-cell symbol. The level always flips at a symbol boundary. It flips again at mid-symbol only when the bit is 1.

The encoder keeps the last symbol it produced, so the line polarity carries on without a break from one word into the next. Words enter through a valid/ready port. A single output pin presents one cell at a time and advances on each pulse of a cell-rate enable. The symbol state is also visible on a port.

Back-pressure rules for the word port:
- A word is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` stays low from the cycle after acceptance until the final cell of that word has been consumed by a `cell_en` pulse.
- While `in_ready` is low, `in_valid` and `in_data` have no effect.

Top module: `bmc_line_encoder`

## Requirements
- R1: Each data bit yields exactly two cells, so one accepted word occupies exactly 64 `cell_en` pulses before `in_ready` returns high. Data bits are coded starting from bit 0 and ending at bit 31.
- R2: Symbols are 2-bit values whose high bit is the earlier cell. The symbol for a bit depends on the bit and on the previous symbol:
  - For bit 1, the symbol is 2 when the previous symbol is 0 or 2, and 1 when it is 1 or 3.
  - For bit 0, the symbol is 3 when the previous symbol is 0 or 2, and 0 when it is 1 or 3.
- R3: The symbol of data bit 0 is sent first and that of bit 31 last. Within a symbol, the high bit is sent before the low bit.
- R4: The previous-symbol state used for the first bit of a word is the last symbol of the prior accepted word. Therefore the first cell of a word always differs from the final cell of the prior word.
- R5: After synchronous reset, `line_out` is 0, `in_ready` is 1 and `last_sym` is 0.
- R6: After a word is accepted, `line_out` presents its first cell from the next cycle. `in_ready` is low from that cycle until the 64th `cell_en` pulse.
- R7: While a word is in flight, `line_out` advances by one cell on each clock with `cell_en` high. It holds on clocks without `cell_en`.
- R8: When no word is in flight, `line_out` holds the level of the final cell sent, whatever `cell_en` does.
- R9: `last_sym` takes the last symbol of a word (the symbol of bit 31) in the cycle after acceptance. It is unchanged by any `in_valid` or `in_data` activity while `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Encoder can take a word |
| in_data | input | 32 | Data word, bit 0 coded first |
| cell_en | input | 1 | Cell-rate enable, one cell per pulse |
| line_out | output | 1 | Current line cell |
| last_sym | output | 2 | Last symbol of the most recently accepted word |

## Verification
A wrong symbol state appears as a wrong first cell on `line_out` in the cycle right after the next word is accepted. It also appears one cycle after acceptance as a wrong `last_sym` value. A miscounted cell counter shows as `in_ready` rising early or late against the 64th enable pulse. A shifter fault shows as a wrong level at the first affected cell. The bench compares all three outputs against a behavioural model on every cycle, so any such fault is reported in the cycle it first reaches a port.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int unsigned SYM_W = 2;
  typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/bmc_symbol_map.sv
// One bit to one two-cell symbol. Only the final cell of the previous
// symbol matters: the new symbol starts on the opposite level.
module bmc_symbol_map
  import bmc_pkg::*;
(
  input  logic prev_cell,
  input  logic bit_in,
  output sym_t sym
);
  always_comb begin
    sym[1] = ~prev_cell;
    sym[0] = ~prev_cell ^ bit_in;
  end
endmodule

// File: rtl/bmc_word_coder.sv
// Chains one symbol mapper per data bit. Bit 0 lands in the top pair.
module bmc_word_coder
  import bmc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CELLS = SYM_W * DATA_W
) (
  input  logic              prev_cell,
  input  logic [DATA_W-1:0] data,
  output logic [CELLS-1:0]  code,
  output sym_t              final_sym
);
  logic [DATA_W:0] link;
  assign link[0] = prev_cell;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    sym_t s;
    bmc_symbol_map u_map (
      .prev_cell(link[i]),
      .bit_in   (data[i]),
      .sym      (s)
    );
    assign code[CELLS-1-SYM_W*i -: SYM_W] = s;
    assign link[i+1] = s[0];
  end

  assign final_sym = code[SYM_W-1:0];
endmodule

// File: rtl/bmc_cell_shifter.sv
// Holds the coded word and presents one cell per enable, top cell first.
// The final cell stays on the line once the word is used up.
module bmc_cell_shifter #(
  parameter int unsigned CELLS = 64,
  localparam int unsigned CNT_W = $clog2(CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CELLS-1:0] load_code,
  input  logic             cell_en,
  output logic             line,
  output logic             busy
);
  logic [CELLS-1:0] sh;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= load_code;
      left <= CNT_W'(CELLS);
    end else if (cell_en && left != '0) begin
      left <= left - 1'b1;
      if (left != CNT_W'(1)) sh <= {sh[CELLS-2:0], 1'b0};
    end
  end

  assign line = sh[CELLS-1];
  assign busy = (left != '0);

  // R7: no enable and no load means the line does not move
  p_hold_no_enable_r7: assert property (@(posedge clk) disable iff (rst)
    !load && !cell_en |=> $stable(line));
  // R8: idle line stays put whatever the enable does
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !busy && !load |=> $stable(line));
  // R6: a load makes the shifter busy in the next cycle
  p_busy_after_load_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
  // R6: busy ends only on an enable pulse
  p_release_on_enable_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cell_en));
endmodule

// File: rtl/bmc_line_encoder.sv
module bmc_line_encoder
  import bmc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CELLS = SYM_W * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cell_en,
  output logic              line_out,
  output logic [1:0]        last_sym
);
  logic             busy;
  logic             accept;
  logic [CELLS-1:0] code;
  sym_t             final_sym;
  sym_t             state_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  bmc_word_coder #(.DATA_W(DATA_W)) u_coder (
    .prev_cell(state_q[0]),
    .data     (in_data),
    .code     (code),
    .final_sym(final_sym)
  );

  bmc_cell_shifter #(.CELLS(CELLS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_code(code),
    .cell_en  (cell_en),
    .line     (line_out),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else if (accept) state_q <= final_sym;
  end

  assign last_sym = state_q;

  // R4: first cell of a new word is the opposite of the prior final cell
  p_first_cell_flips_r4: assert property (@(posedge clk) disable iff (rst)
    accept |=> line_out != $past(last_sym[0]));
  // R9: symbol state moves only on acceptance
  p_state_held_r9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(last_sym));
  // R6: no second word while one is in flight
  p_ready_drops_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);
endmodule

// File: tb/test_bmc_line_encoder.sv
`timescale 1ns/100ps
module test_bmc_line_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic cell_en = 1'b0;
  logic in_ready;
  logic line_out;
  logic [1:0] last_sym;

  always #2.5 clk = ~clk;

  bmc_line_encoder i_bmc_line_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cell_en(cell_en), .line_out(line_out), .last_sym(last_sym)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  bit m_cells[$];
  bit m_line = 0;
  int m_rem = 0;
  int m_last = 0;
  int phase = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit rs, input bit v, input logic [31:0] d, input bit ce);
    if (rs) begin
      m_cells.delete(); m_line = 0; m_rem = 0; m_last = 0;
    end else if (v && m_rem == 0) begin
      int p;
      p = m_last;
      m_cells.delete();
      for (int b = 0; b < 32; b++) begin
        int s;
        if (d[b]) s = (p == 0 || p == 2) ? 2 : 1;
        else      s = (p == 0 || p == 2) ? 3 : 0;
        m_cells.push_back(s[1]);
        m_cells.push_back(s[0]);
        p = s;
      end
      m_last = p;
      m_line = m_cells[0];
      m_rem = 64;
    end else if (ce && m_rem > 0) begin
      if (m_rem > 1) begin
        void'(m_cells.pop_front());
        m_line = m_cells[0];
      end
      m_rem--;
    end
  endtask

  task automatic compare_all();
    chk(line_out === m_line, "R2 R3 R7 line_out", 64'(line_out), 64'(m_line));
    chk(in_ready === (m_rem == 0), "R6 in_ready", 64'(in_ready), 64'(m_rem == 0));
    chk(last_sym === 2'(m_last), "R4 R9 last_sym", 64'(last_sym), 64'(m_last));
  endtask

  task automatic cyc(input bit v, input logic [31:0] d, input bit ce);
    in_valid = v; in_data = d; cell_en = ce;
    @(posedge clk);
    #1 model_step(rst, v, d, ce);
    @(negedge clk);
    compare_all();
  endtask

  function automatic bit pick_ce(input int mode);
    phase++;
    case (mode)
      0: return 1'b1;
      1: return (phase % 3) == 0;
      default: return 1'(($urandom % 4) != 0);
    endcase
  endfunction

  // offer a word, stream it out, count enables used (R1), check idle hold (R8)
  task automatic send(input logic [31:0] d, input int mode, input bit noise);
    int used;
    bit lvl;
    used = 0;
    while (in_ready !== 1'b1) cyc(0, '0, 1'b1);
    cyc(1, d, pick_ce(mode));
    while (in_ready === 1'b0) begin
      bit ce;
      ce = pick_ce(mode);
      if (ce) used++;
      cyc(noise ? 1'(($urandom % 2)) : 1'b0, $urandom, ce);
    end
    chk(used == 64, "R1 enables per word", 64'(used), 64'd64);
    lvl = line_out;
    chk(lvl == 1'(m_last & 1), "R8 idle level is final cell", 64'(lvl), 64'(m_last & 1));
    for (int k = 0; k < 4; k++) begin
      in_valid = 0; cell_en = 1'(k % 2);
      @(posedge clk); #1 model_step(0, 0, '0, 1'(k % 2)); @(negedge clk);
      chk(line_out === lvl, "R8 idle hold", 64'(line_out), 64'(lvl));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) cyc(0, '0, 1'b0);
    // R5 reset state
    chk(line_out === 1'b0, "R5 line after reset", 64'(line_out), 64'd0);
    chk(in_ready === 1'b1, "R5 ready after reset", 64'(in_ready), 64'd1);
    chk(last_sym === 2'd0, "R5 state after reset", 64'(last_sym), 64'd0);
    rst = 0;
    cyc(0, '0, 1'b1);

    // R2 all zeros from state 0: 3,0,3,0... last symbol 0
    send(32'h0000_0000, 0, 0);
    chk(last_sym === 2'd0, "R2 zeros word final symbol", 64'(last_sym), 64'd0);
    // R2 all ones from state 0: every symbol 2
    send(32'hFFFF_FFFF, 0, 0);
    chk(last_sym === 2'd2, "R2 ones word final symbol", 64'(last_sym), 64'd2);
    // R3 R4 single low bit set, starts from state 2: 2 then 3,0,... last 3
    send(32'h0000_0001, 1, 0);
    chk(last_sym === 2'd3, "R3 R4 lsb-only word final symbol", 64'(last_sym), 64'd3);
    send(32'h8000_0000, 1, 1);   // R9: valid noise while busy
    send(32'hA5A5_5A5A, 2, 1);
    for (int n = 0; n < 25; n++) send($urandom, n % 3, 1'(n % 2));

    // R5 reset in mid-word
    cyc(1, 32'h1234_5678, 1'b1);
    repeat (5) cyc(0, '0, 1'b1);
    rst = 1;
    cyc(0, '0, 1'b1);
    chk(in_ready === 1'b1, "R5 ready after mid-word reset", 64'(in_ready), 64'd1);
    chk(last_sym === 2'd0, "R5 state after mid-word reset", 64'(last_sym), 64'd0);
    rst = 0;
    send(32'hDEAD_BEEF, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule